// File: doc/BRIEF.md
# Mixed Push-Pull / Open-Drain I2C Port Expander

This block is an I2C target that controls an eight-pin port of two kinds. Pins 7, 6, 1 and 0 are push-pull outputs. Pins 5 to 2 are open-drain lines that can also serve as inputs. Those inputs have change detection and a per-pin interrupt enable. A write of one data byte sets the push-pull levels and, in the same byte, the open-drain bits. A 1 in an open-drain position releases the pin and enables its change detection. A 0 drives the pin low and masks its detection.

A read returns two kinds of byte in turn. The first is the level on all eight pins. The second is the byte of change flags. Reading the flag byte clears the flags. While any enabled flag is set, the block pulls an active-low open-drain interrupt line low.

The integrator supplies the SCL and SDA levels already synchronized, and the low four address bits already resolved from the address pins. Two default levels are also inputs. `def_lo` sets the reset state of pins 3..0 and the pull-up enables of pins 3 and 2. `def_hi` does the same for pins 7..4 and pins 5 and 4. All pad drive is expressed as output-enable controls.

Top module: `pxp_expander`

## Requirements
- R1: The block acknowledges only the 7-bit address formed as binary 110 followed by `addr_low[3:0]`, sent MSB first with the R/W bit last (1 = read). Any other address gets no acknowledge and leaves the port unchanged.
- R2: After a written byte is committed, each push-pull pin k (k = 7, 6, 1, 0) has `pin_oe[k]`=1 and `pin_out[k]` equal to data bit k. Between writes the port latch does not change.
- R3: Each open-drain pin k (k = 5..2) has `pin_out[k]`=0 and `pin_oe[k]` equal to the inverse of the last written data bit k. A 1 releases the pin and a 0 drives it low.
- R4: Reset loads data bits 3..0 with `def_lo` and bits 7..4 with `def_hi`. The pad outputs then follow R2 and R3 from these values.
- R5: `pull_en[1:0]` (pull-ups of pins 3 and 2) equal `def_lo`, and `pull_en[3:2]` (pins 5 and 4) equal `def_hi`.
- R6: In a read, the first data byte and every odd-numbered byte after it carry `pin_in[7:0]`, the levels at the time the byte is loaded.
- R7: The second read byte carries the change flags of pins 5..2 in bit positions 5..2. Bits 7, 6, 1 and 0 read 0. Loading that byte clears all flags.
- R8: The flag of an open-drain pin is set when its data bit is 1 and `pin_in` differs from the level captured at the last port-level read (or at reset). Once set, it stays set until the flag byte is read, even if the pin returns to that level. A pin whose data bit is 0 never sets its flag.
- R9: `irq_oe` is 1 (interrupt line pulled low) while any flag of an enabled pin is set. It is 0 in the cycle after the flag byte is loaded.
- R10: On a read, a master NACK ends the data phase. The block leaves SDA released (`sda_oe`=0) until the next START.
- R11: The block acknowledges its address and every written data byte. Each byte is committed on its own, so in a multi-byte write the last byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_low | input | 4 | Resolved low address bits |
| def_lo | input | 1 | Default level and pull-up select for the low group |
| def_hi | input | 1 | Default level and pull-up select for the high group |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Level driven when the pin is enabled |
| pin_oe | output | 8 | Per-pin output enable |
| pull_en | output | 4 | Pull-up enables for pins 2, 3, 4 and 5 (bit 0 = pin 2) |
| irq_oe | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The port is driven with several byte patterns through the bus.
- Writes use all-released and mixed driven/released open-drain codes, so a swapped push-pull/open-drain split or an inverted release sense shows up on the pads.
- Two address patterns that miss, one in the low bits and one in the fixed upper bits, separate a full compare from a partial one.
- Input changes are placed on enabled pins, on masked pins and on push-pull pins. This shows that only enabled open-drain pins raise flags, and that push-pull positions read zero in the flag byte.
- A short low pulse that returns to the captured level shows that flags are sticky.
- A read that ends after one byte shows two things: the NACK is honoured, and the flags survive until the flag byte itself is read.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
    localparam int PORT_W    = 8;
    localparam int OD_LSB    = 2;
    localparam int OD_W      = 4;
    localparam int HALF_W    = PORT_W / 2;
    localparam int BIT_CNT_W = $clog2(PORT_W + 1);
    localparam logic [PORT_W-1:0] PP_MASK = 8'hC3;

    typedef logic [PORT_W-1:0] byte_t;
    typedef logic [OD_W-1:0]   od_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } link_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic byte_t place_flags(od_t f);
        byte_t b;
        b = '0;
        b[OD_LSB +: OD_W] = f;
        return b;
    endfunction

    function automatic byte_t reset_latch(logic lo, logic hi);
        return {{HALF_W{hi}}, {HALF_W{lo}}};
    endfunction
endpackage

// File: rtl/pxp_line_events.sv
module pxp_line_events
    import pxp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        ev.scl_rise = scl_in & ~scl_q;
        ev.scl_fall = ~scl_in & scl_q;
        ev.start    = scl_in & scl_q & sda_q & ~sda_in;
        ev.stop     = scl_in & scl_q & ~sda_q & sda_in;
        ev.sda      = sda_in;
    end
endmodule

// File: rtl/pxp_link_fsm.sv
module pxp_link_fsm
    import pxp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 4,
    parameter logic [ADDR_W-LOW_W-1:0] ADDR_HI = 3'b110
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    input  logic [LOW_W-1:0] addr_low,
    input  byte_t            tx_port,
    input  byte_t            tx_flag,
    output logic             sda_oe,
    output logic             wr_stb,
    output byte_t            wr_data,
    output logic             rd_port_stb,
    output logic             rd_flag_stb
);
    localparam logic [BIT_CNT_W-1:0] CNT_FULL = BIT_CNT_W'(PORT_W);
    localparam logic [BIT_CNT_W-1:0] CNT_LAST = BIT_CNT_W'(PORT_W - 1);
    localparam logic [BIT_CNT_W-1:0] CNT_ONE  = BIT_CNT_W'(1);

    link_st_e             st;
    logic [BIT_CNT_W-1:0] cnt;
    byte_t                sh;
    byte_t                tx;
    logic                 rw;
    logic                 nack;
    logic                 sel_flag;
    logic [ADDR_W-1:0]    own_addr;
    logic                 quiet;
    logic                 next_ok;
    byte_t                next_byte;

    assign own_addr  = {ADDR_HI, addr_low};
    assign quiet     = ~ev.start & ~ev.stop;
    assign next_ok   = quiet & ev.scl_fall & (st == ST_RACK) & ~nack;
    assign next_byte = sel_flag ? tx_flag : tx_port;

    assign wr_data     = sh;
    assign wr_stb      = quiet & ev.scl_fall & (st == ST_WR) & (cnt == CNT_FULL);
    assign rd_port_stb = (quiet & ev.scl_fall & (st == ST_AACK) & rw) | (next_ok & ~sel_flag);
    assign rd_flag_stb = next_ok & sel_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sel_flag <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_ADDR, ST_WR: begin
                    if (ev.scl_rise) begin
                        sh  <= {sh[PORT_W-2:0], ev.sda};
                        cnt <= cnt + CNT_ONE;
                    end else if (ev.scl_fall && cnt == CNT_FULL) begin
                        if (st == ST_ADDR) begin
                            if (sh[PORT_W-1:1] == own_addr) begin
                                st     <= ST_AACK;
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            st     <= ST_WACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            st       <= ST_RD;
                            tx       <= tx_port;
                            sda_oe   <= ~tx_port[PORT_W-1];
                            sel_flag <= 1'b1;
                        end else begin
                            st     <= ST_WR;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (ev.scl_fall) begin
                        st     <= ST_WR;
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                    end
                end
                ST_RD: begin
                    if (ev.scl_fall) begin
                        if (cnt == CNT_LAST) begin
                            st     <= ST_RACK;
                            sda_oe <= 1'b0;
                        end else begin
                            tx     <= {tx[PORT_W-2:0], 1'b0};
                            sda_oe <= ~tx[PORT_W-2];
                            cnt    <= cnt + CNT_ONE;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        nack <= ev.sda;
                    end else if (ev.scl_fall) begin
                        if (nack) begin
                            st <= ST_IDLE;
                        end else begin
                            st       <= ST_RD;
                            cnt      <= '0;
                            tx       <= next_byte;
                            sda_oe   <= ~next_byte[PORT_W-1];
                            sel_flag <= ~sel_flag;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_OWN_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AACK && $past(st) == ST_ADDR) |-> ($past(sh[PORT_W-1:1]) == own_addr)); // R1

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RACK && ev.scl_fall && nack && quiet) |=> (!sda_oe && st == ST_IDLE)); // R10

    AST_DATA_ACK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WACK) |-> sda_oe); // R11
endmodule

// File: rtl/pxp_port_core.sv
module pxp_port_core
    import pxp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  def_lo,
    input  logic  def_hi,
    input  logic  wr_stb,
    input  byte_t wr_data,
    input  logic  rd_port_stb,
    input  logic  rd_flag_stb,
    input  byte_t pin_in,
    output byte_t pin_out,
    output byte_t pin_oe,
    output byte_t port_byte,
    output byte_t flag_byte,
    output logic  irq_oe
);
    byte_t wr_q;
    od_t   ref_q;
    od_t   flag_q;
    od_t   en;
    od_t   diff;

    assign en   = wr_q[OD_LSB +: OD_W];
    assign diff = pin_in[OD_LSB +: OD_W] ^ ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= reset_latch(def_lo, def_hi);
            ref_q  <= pin_in[OD_LSB +: OD_W];
            flag_q <= '0;
        end else begin
            if (wr_stb) begin
                wr_q <= wr_data;
            end
            if (rd_port_stb) begin
                ref_q <= pin_in[OD_LSB +: OD_W];
            end
            if (rd_flag_stb) begin
                flag_q <= '0;
            end else begin
                flag_q <= flag_q | (en & diff);
            end
        end
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_pad
        if (PP_MASK[i]) begin : g_pp
            assign pin_oe[i]  = 1'b1;
            assign pin_out[i] = wr_q[i];
        end else begin : g_od
            assign pin_oe[i]  = ~wr_q[i];
            assign pin_out[i] = 1'b0;
        end
    end

    assign port_byte = pin_in;
    assign flag_byte = place_flags(flag_q);
    assign irq_oe    = |(flag_q & en);

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(wr_q)); // R2

    AST_MASKED_NEVER_FLAGS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(en)) == '0)); // R8

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_flag_stb |=> (flag_q == '0 && !irq_oe)); // R9
endmodule

// File: rtl/pxp_expander.sv
module pxp_expander
    import pxp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int LOW_W  = 4,
    parameter logic [ADDR_W-LOW_W-1:0] ADDR_HI = 3'b110
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [LOW_W-1:0] addr_low,
    input  logic             def_lo,
    input  logic             def_hi,
    input  logic [7:0]       pin_in,
    output logic [7:0]       pin_out,
    output logic [7:0]       pin_oe,
    output logic [3:0]       pull_en,
    output logic             irq_oe
);
    line_ev_t ev;
    logic     wr_stb;
    byte_t    wr_data;
    logic     rd_port_stb;
    logic     rd_flag_stb;
    byte_t    port_byte;
    byte_t    flag_byte;

    pxp_line_events u_events (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    pxp_link_fsm #(
        .ADDR_W  (ADDR_W),
        .LOW_W   (LOW_W),
        .ADDR_HI (ADDR_HI)
    ) u_link (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .addr_low    (addr_low),
        .tx_port     (port_byte),
        .tx_flag     (flag_byte),
        .sda_oe      (sda_oe),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rd_port_stb (rd_port_stb),
        .rd_flag_stb (rd_flag_stb)
    );

    pxp_port_core u_core (
        .clk         (clk),
        .rst         (rst),
        .def_lo      (def_lo),
        .def_hi      (def_hi),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .rd_port_stb (rd_port_stb),
        .rd_flag_stb (rd_flag_stb),
        .pin_in      (pin_in),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe),
        .port_byte   (port_byte),
        .flag_byte   (flag_byte),
        .irq_oe      (irq_oe)
    );

    assign pull_en = {def_hi, def_hi, def_lo, def_lo};
endmodule

// File: tb/pxp_expander_test.sv
module pxp_expander_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       sda_oe;
    logic [3:0] addr_low = 4'h5;
    logic       def_lo = 1'b1;
    logic       def_hi = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [3:0] pull_en;
    logic       irq_oe;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    logic [7:0] m_wr = 8'h0F;
    logic [3:0] m_ref = 4'h0;
    logic [3:0] m_flag = 4'h0;

    always #10 clk = ~clk;

    assign sda_line = ~(m_sda_low | sda_oe);

    pxp_expander uut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .addr_low (addr_low),
        .def_lo   (def_lo),
        .def_hi   (def_hi),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .pull_en  (pull_en),
        .irq_oe   (irq_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_oe(logic [7:0] w);
        return 8'hC3 | (~w & 8'h3C);
    endfunction

    function automatic logic [7:0] exp_out(logic [7:0] w);
        return w & 8'hC3;
    endfunction

    // behavioural reference for the change flags
    always @(posedge clk) begin
        if (rst) begin
            m_flag = 4'h0;
            m_ref  = pin_in[5:2];
        end else begin
            m_flag = m_flag | (m_wr[5:2] & (pin_in[5:2] ^ m_ref));
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_en && !done) begin
            check(pin_oe == exp_oe(m_wr), "R2 R3 pin_oe", pin_oe, exp_oe(m_wr));
            check(pin_out == exp_out(m_wr), "R2 R3 pin_out", pin_out, exp_out(m_wr));
            check(irq_oe == |(m_flag & m_wr[5:2]), "R9 irq_oe", irq_oe, |(m_flag & m_wr[5:2]));
        end
    end

    task automatic hp;
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda_low = 1'b0; m_scl = 1'b1; hp;
        m_sda_low = 1'b1; hp;
        m_scl = 1'b0; hp;
    endtask

    task automatic bus_stop;
        m_sda_low = 1'b1; hp;
        m_scl = 1'b1; hp;
        m_sda_low = 1'b0; hp;
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; hp;
            m_scl = 1'b1; hp;
            m_scl = 1'b0;
        end
        m_sda_low = 1'b0; hp;
        m_scl = 1'b1; hp;
        ack = ~sda_line;
        m_scl = 1'b0; hp;
    endtask

    task automatic get_byte(input bit nack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            hp;
            m_scl = 1'b1; hp;
            b[i] = sda_line;
            m_scl = 1'b0;
        end
        m_sda_low = ~nack; hp;
        m_scl = 1'b1; hp;
        m_scl = 1'b0; hp;
        m_sda_low = 1'b0;
    endtask

    task automatic write_txn(input logic [6:0] a, input int n, input logic [7:0] d0,
                             input logic [7:0] d1, output bit aack, output bit dack);
        bit k;
        cmp_en = 1'b0;
        dack = 1'b1;
        bus_start;
        put_byte({a, 1'b0}, aack);
        if (aack) begin
            put_byte(d0, k); dack &= k;
            if (n > 1) begin put_byte(d1, k); dack &= k; end
        end
        bus_stop;
        repeat (2) @(negedge clk);
        if (aack) m_wr = (n > 1) ? d1 : d0;
        cmp_en = 1'b1;
    endtask

    task automatic read_txn(input logic [6:0] a, input int n, output bit aack,
                            output logic [7:0] b0, output logic [7:0] b1);
        cmp_en = 1'b0;
        b0 = 8'h00; b1 = 8'h00;
        bus_start;
        put_byte({a, 1'b1}, aack);
        if (aack) begin
            get_byte(n == 1, b0);
            if (n == 1) begin
                repeat (12) @(negedge clk);
                check(sda_oe == 1'b0, "R10 sda released after NACK", sda_oe, 0);
                check(sda_line == 1'b1, "R10 sda line high after NACK", sda_line, 1);
            end else begin
                get_byte(1'b1, b1);
            end
        end
        bus_stop;
        repeat (2) @(negedge clk);
        if (aack) begin
            m_ref = pin_in[5:2];
            if (n > 1) m_flag = 4'h0;
        end
        cmp_en = 1'b1;
    endtask

    initial begin
        bit aack, dack;
        logic [7:0] b0, b1;

        // reset pattern A: def_lo=1, def_hi=0
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pin_oe == 8'hF3, "R4 reset A pin_oe", pin_oe, 8'hF3);
        check(pin_out == 8'h03, "R4 reset A pin_out", pin_out, 8'h03);
        check(pull_en == 4'b0011, "R5 reset A pull_en", pull_en, 4'b0011);
        check(irq_oe == 1'b0 && sda_oe == 1'b0, "R4 reset idle outputs", {irq_oe, sda_oe}, 0);

        // reset pattern B: def_lo=0, def_hi=1
        rst = 1'b1; def_lo = 1'b0; def_hi = 1'b1; m_wr = 8'hF0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pin_oe == 8'hCF, "R4 reset B pin_oe", pin_oe, 8'hCF);
        check(pin_out == 8'hC0, "R4 reset B pin_out", pin_out, 8'hC0);
        check(pull_en == 4'b1100, "R5 reset B pull_en", pull_en, 4'b1100);
        cmp_en = 1'b1;

        // R1: wrong low bits, then wrong fixed bits
        write_txn(7'b110_0110, 1, 8'h00, 8'h00, aack, dack);
        check(aack == 1'b0, "R1 low-bit mismatch not acked", aack, 0);
        write_txn(7'b101_0101, 1, 8'h00, 8'h00, aack, dack);
        check(aack == 1'b0, "R1 high-bit mismatch not acked", aack, 0);
        check(pin_out == 8'hC0 && pin_oe == 8'hCF, "R1 port unchanged after mismatch", {pin_oe, pin_out}, 16'hCFC0);

        // R11/R2/R3: two-byte write, last wins, all open-drain released
        write_txn(7'b110_0101, 2, 8'h00, 8'hBD, aack, dack);
        check(aack == 1'b1, "R11 own address acked", aack, 1);
        check(dack == 1'b1, "R11 data bytes acked", dack, 1);
        check(pin_out == 8'h81, "R2 push-pull levels last byte", pin_out, 8'h81);
        check(pin_oe == 8'hC3, "R3 open-drain released", pin_oe, 8'hC3);

        // R3: pins 5 and 3 driven low, 4 and 2 released
        write_txn(7'b110_0101, 1, 8'hD5, 8'h00, aack, dack);
        check(pin_oe == 8'hEB, "R3 mixed open-drain enables", pin_oe, 8'hEB);
        check(pin_out == 8'hC1, "R3 open-drain drives zero", pin_out, 8'hC1);

        // R6/R7/R8/R9: enabled pin 2 changes, masked pin 5 and push-pull pins too
        pin_in = 8'hA6;
        repeat (4) @(negedge clk);
        check(irq_oe == 1'b1, "R9 irq on enabled change", irq_oe, 1);
        read_txn(7'b110_0101, 2, aack, b0, b1);
        check(b0 == 8'hA6, "R6 port byte", b0, 8'hA6);
        check(b1 == 8'h04, "R7 flag byte pin2 only", b1, 8'h04);
        check(irq_oe == 1'b0, "R9 irq released after flag read", irq_oe, 0);

        // R8: masked pins 5 and 3 change, no flag
        pin_in = 8'h8E;
        repeat (6) @(negedge clk);
        check(irq_oe == 1'b0, "R8 masked change no irq", irq_oe, 0);
        read_txn(7'b110_0101, 2, aack, b0, b1);
        check(b0 == 8'h8E, "R6 port byte masked case", b0, 8'h8E);
        check(b1 == 8'h00, "R8 masked flags zero", b1, 8'h00);

        // R10: enabled pin 4 plus push-pull pins change, read one byte with NACK
        pin_in = 8'h1F;
        repeat (4) @(negedge clk);
        check(irq_oe == 1'b1, "R9 irq on pin4 change", irq_oe, 1);
        read_txn(7'b110_0101, 1, aack, b0, b1);
        check(b0 == 8'h1F, "R6 port byte before NACK", b0, 8'h1F);
        check(irq_oe == 1'b1, "R9 flags kept without flag read", irq_oe, 1);
        read_txn(7'b110_0101, 2, aack, b0, b1);
        check(b1 == 8'h10, "R7 flag byte pin4, push-pull zero", b1, 8'h10);

        // R8: short pulse back to captured level keeps flag
        pin_in = 8'h1B;
        repeat (3) @(negedge clk);
        pin_in = 8'h1F;
        repeat (4) @(negedge clk);
        check(irq_oe == 1'b1, "R8 sticky flag after pulse", irq_oe, 1);
        read_txn(7'b110_0101, 2, aack, b0, b1);
        check(b0 == 8'h1F, "R6 port byte after pulse", b0, 8'h1F);
        check(b1 == 8'h04, "R8 sticky flag read", b1, 8'h04);
        check(irq_oe == 1'b0, "R9 irq cleared", irq_oe, 0);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 R11 act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule